// File: doc/BRIEF.md
# Four-Way Instruction Cache with Blocking Burst Refill

This block is a read-only instruction cache that sits between a processor fetch port and a main-memory burst interface. Fetch addresses and instruction words are both 32 bits wide. The storage holds 8 KB in 128 sets of four ways, and each line is 16 bytes, or four words. When a fetch hits, the block returns the addressed word in the same cycle and does not stall.

When a fetch misses, the block raises `stall` and keeps it high. It requests the whole line from memory, giving the line-aligned address. It then accepts four word beats in ascending order, writes each one into the chosen way, and marks the line valid after the last beat. The fetch port keeps its request steady during the stall. The request is served as a hit in the cycle after the last beat is written.

The victim way is the lowest-numbered invalid way in the set. When all four ways are valid, a three-bit tree pseudo-LRU picks the victim. A one-cycle `flush` input invalidates every line.

Top module: `icache_burst`

## Requirements
- R1: After reset `stall`, `rsp_valid` and `mem_req` are low and every line is invalid, so the first fetch to any address misses.
- R2: A fetch that hits gives `rsp_valid` high and `stall` low in the same cycle. `rsp_data` is the word that address bits [3:2] select within the line.
- R3: A miss keeps `stall` high from the cycle the request is presented until the last beat is written. With memory beats arriving at the 33rd, 35th, 37th and 39th cycles of `mem_req`, the miss shows exactly 40 stall cycles, and the response comes in the 41st cycle.
- R4: `mem_req` rises in the cycle after the miss and stays high, with `mem_addr` stable at the line base (low four bits zero), until the fourth beat. Beat k is stored as word k of the line.
- R5: After a refill, every word of that line hits without stall until the line is evicted or flushed.
- R6: Bits [10:4] of the address select the set and bits [31:4+7] form the tag. On a miss, the lowest-numbered invalid way of the set is filled.
- R7: When all four ways of the set are valid, the victim comes from a tree of three bits: a root bit and a bit for each pair of ways. If the root is 0 the pair {0,1} is used, otherwise the pair {2,3}. Within the pair, a bit of 0 picks the lower way. A hit or a fill of a way points the root at the other pair and points that pair's bit at the other way.
- R8: A cycle with `flush` high invalidates all lines. The next fetch to any previously cached line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | 32 | Fetch byte address |
| rsp_valid | output | 1 | Hit response this cycle |
| rsp_data | output | 32 | Instruction word |
| stall | output | 1 | Fetch must hold and wait |
| mem_req | output | 1 | Line read in progress |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_data_valid | input | 1 | Memory beat present |
| mem_data | input | 32 | Memory beat word |

## Verification
Directed fetches first show the cold miss after reset. They then show hits on all four words of the freshly filled line, which separates the word ordering of the burst from a wrong beat index. Five tags forced into one set separate first-invalid filling from pseudo-LRU eviction: the evicted tag misses again, while the others stay hits.

Seeded random fetches then use a handful of sets and tags so that conflicts are frequent. Random flushes and idle gaps are mixed in. A bench model of tags, valid bits and tree bits predicts, for each fetch, whether it hits or misses and which line is lost. Exact stall counts, the response data and the refill address are all checked against that model.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int AW         = 32;
  localparam int DW         = 32;
  localparam int WAYS       = 4;
  localparam int SETS       = 128;
  localparam int LINE_WORDS = 4;
  localparam int OFF_W      = $clog2(LINE_WORDS * DW / 8);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = AW - IDX_W - OFF_W;
  localparam int WAY_W      = $clog2(WAYS);
  localparam int WORD_W     = $clog2(LINE_WORDS);
  localparam int TREE_W     = WAYS - 1;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [WAY_W-1:0]  way_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [TREE_W-1:0] tree_t;

  function automatic tag_t addr_tag(input logic [AW-1:0] a);
    return a[AW-1 -: TAG_W];
  endfunction

  function automatic idx_t addr_idx(input logic [AW-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic word_t addr_word(input logic [AW-1:0] a);
    return a[2 +: WORD_W];
  endfunction

  // bit0 root, bit1 pair {0,1}, bit2 pair {2,3}
  function automatic way_t tree_victim(input tree_t b);
    return b[0] ? (b[2] ? way_t'(3) : way_t'(2)) : (b[1] ? way_t'(1) : way_t'(0));
  endfunction

  function automatic tree_t tree_touch(input tree_t b, input way_t w);
    tree_t n = b;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  // {found, way}: lowest-numbered invalid way
  function automatic logic [WAY_W:0] first_free(input logic [WAYS-1:0] v);
    logic [WAY_W:0] r = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!v[i]) r = {1'b1, way_t'(i)};
    return r;
  endfunction

  function automatic way_t onehot_way(input logic [WAYS-1:0] v);
    way_t r = '0;
    for (int i = 0; i < WAYS; i++)
      if (v[i]) r = way_t'(i);
    return r;
  endfunction
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store
  import icache_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  idx_t            rd_idx,
  input  tag_t            rd_tag,
  output logic [WAYS-1:0] hit_vec,
  output logic [WAYS-1:0] valid_vec,
  input  logic            fill_we,
  input  idx_t            fill_idx,
  input  way_t            fill_way,
  input  tag_t            fill_tag
);
  logic [WAYS-1:0] valid_q [SETS];
  tag_t            tag_q   [SETS][WAYS];
  logic            any_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      if (flush)
        for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      if (fill_we) valid_q[fill_idx][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) tag_q[fill_idx][fill_way] <= fill_tag;
  end

  assign valid_vec = valid_q[rd_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag);
  end

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
  end

  // R6: a tag lives in at most one way of a set
  a_r6_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R8: flush leaves nothing valid
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !fill_we |=> !any_valid);
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store
  import icache_pkg::*;
(
  input  logic          clk,
  input  idx_t          rd_idx,
  input  way_t          rd_way,
  input  word_t         rd_word,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  idx_t          wr_idx,
  input  way_t          wr_way,
  input  word_t         wr_word,
  input  logic [DW-1:0] wr_data
);
  localparam int DEPTH = SETS * WAYS * LINE_WORDS;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[{wr_idx, wr_way, wr_word}] <= wr_data;
  end

  assign rd_data = mem_q[{rd_idx, rd_way, rd_word}];
endmodule

// File: rtl/icache_plru.sv
module icache_plru
  import icache_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  idx_t            rd_idx,
  input  logic [WAYS-1:0] valid_vec,
  output way_t            victim,
  input  logic            hit_touch,
  input  way_t            hit_way,
  input  logic            fill_touch,
  input  idx_t            fill_idx,
  input  way_t            fill_way
);
  tree_t          tree_q [SETS];
  logic [WAY_W:0] free;

  assign free   = first_free(valid_vec);
  assign victim = free[WAY_W] ? free[WAY_W-1:0] : tree_victim(tree_q[rd_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (fill_touch) begin
      tree_q[fill_idx] <= tree_touch(tree_q[fill_idx], fill_way);
    end else if (hit_touch) begin
      tree_q[rd_idx] <= tree_touch(tree_q[rd_idx], hit_way);
    end
  end

  // R6: with a free way in the set the victim is never a valid way
  a_r6_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_vec != '1) |-> !valid_vec[victim]);
  // R7: a touched way is not the next tree victim of its set
  a_r7_touch_protects: assert property (@(posedge clk) disable iff (!rst_n)
    hit_touch && !fill_touch |=> tree_victim(tree_q[$past(rd_idx)]) != $past(hit_way));
endmodule

// File: rtl/icache_refill_fsm.sv
module icache_refill_fsm
  import icache_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_evt,
  input  idx_t          miss_idx,
  input  tag_t          miss_tag,
  input  way_t          miss_way,
  input  logic          beat_valid,
  output logic          busy,
  output logic [AW-1:0] line_addr,
  output logic          beat_we,
  output word_t         beat_word,
  output logic          line_done,
  output idx_t          fill_idx,
  output way_t          fill_way,
  output tag_t          fill_tag
);
  typedef enum logic {S_IDLE, S_FILL} state_t;
  state_t state_q;
  word_t  beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      beat_q   <= '0;
      fill_idx <= '0;
      fill_way <= '0;
      fill_tag <= '0;
    end else if (state_q == S_IDLE) begin
      if (miss_evt) begin
        state_q  <= S_FILL;
        beat_q   <= '0;
        fill_idx <= miss_idx;
        fill_way <= miss_way;
        fill_tag <= miss_tag;
      end
    end else if (beat_valid) begin
      beat_q <= beat_q + 1'b1;
      if (line_done) state_q <= S_IDLE;
    end
  end

  assign busy      = (state_q == S_FILL);
  assign beat_we   = busy && beat_valid;
  assign beat_word = beat_q;
  assign line_done = beat_we && (beat_q == word_t'(LINE_WORDS - 1));
  assign line_addr = {fill_tag, fill_idx, {OFF_W{1'b0}}};

  // R4: a refill request follows every miss
  a_r4_miss_launches: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> busy);
  // R4: the request ends right after the last beat
  a_r4_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !busy);
endmodule

// File: rtl/icache_burst.sv
module icache_burst
  import icache_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          req_valid,
  input  logic [31:0]   req_addr,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic          stall,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_data_valid,
  input  logic [31:0]   mem_data
);
  idx_t            rd_idx;
  tag_t            rd_tag;
  word_t           rd_word;
  logic [WAYS-1:0] hit_vec, valid_vec;
  way_t            hit_way, victim, fill_way;
  idx_t            fill_idx;
  tag_t            fill_tag;
  word_t           beat_word;
  logic            busy, beat_we, line_done, any_hit, miss_evt, hit_evt;

  assign rd_idx   = addr_idx(req_addr);
  assign rd_tag   = addr_tag(req_addr);
  assign rd_word  = addr_word(req_addr);
  assign any_hit  = |hit_vec;
  assign hit_way  = onehot_way(hit_vec);
  assign hit_evt  = req_valid && !busy && any_hit;
  assign miss_evt = req_valid && !busy && !any_hit;

  icache_tag_store i_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rd_idx(rd_idx), .rd_tag(rd_tag), .hit_vec(hit_vec), .valid_vec(valid_vec),
    .fill_we(line_done), .fill_idx(fill_idx), .fill_way(fill_way), .fill_tag(fill_tag)
  );

  icache_data_store i_data (
    .clk(clk), .rd_idx(rd_idx), .rd_way(hit_way), .rd_word(rd_word), .rd_data(rsp_data),
    .wr_en(beat_we), .wr_idx(fill_idx), .wr_way(fill_way), .wr_word(beat_word),
    .wr_data(mem_data)
  );

  icache_plru i_plru (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .valid_vec(valid_vec), .victim(victim),
    .hit_touch(hit_evt), .hit_way(hit_way),
    .fill_touch(line_done), .fill_idx(fill_idx), .fill_way(fill_way)
  );

  icache_refill_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .miss_evt(miss_evt), .miss_idx(rd_idx), .miss_tag(rd_tag),
    .miss_way(victim), .beat_valid(mem_data_valid), .busy(busy), .line_addr(mem_addr),
    .beat_we(beat_we), .beat_word(beat_word), .line_done(line_done),
    .fill_idx(fill_idx), .fill_way(fill_way), .fill_tag(fill_tag)
  );

  assign rsp_valid = hit_evt;
  assign stall     = busy || (req_valid && !any_hit);
  assign mem_req   = busy;

  // R2: a response never coincides with a stall
  a_r2_rsp_not_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !stall);
  // R4: the line address holds for the whole refill
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) |-> $stable(mem_addr));
  // R4: the line address is aligned
  a_r4_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));
  // R1: the cache wakes up idle
  a_r1_idle_after_reset: assert property (@(posedge clk)
    !$past(rst_n) |-> !mem_req);
endmodule

// File: tb/test_icache_burst.sv
module test_icache_burst;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, stall, mem_req, mem_data_valid;
  logic [31:0] rsp_data, mem_addr, mem_data;
  int          mcnt = 0;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;

  // bench model state
  bit          m_val  [128][4];
  logic [20:0] m_tag  [128][4];
  bit          m_root [128];
  bit          m_lo   [128];
  bit          m_hi   [128];

  always #10 clk = ~clk;

  icache_burst i_icache_burst (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .stall(stall), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data_valid(mem_data_valid), .mem_data(mem_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return ((a >> 2) * 32'h9E37_79B1) ^ 32'hC3A5_1E0F;
  endfunction

  // memory: 32 setup cycles, then a beat every second cycle
  always @(posedge clk) mcnt <= mem_req ? mcnt + 1 : 0;
  assign mem_data_valid = mem_req && mcnt >= 32 && mcnt <= 38 && (mcnt % 2 == 0);
  assign mem_data = mem_word(mem_addr + 32'((mcnt - 32) / 2 * 4));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run exceeded cycle limit, actual %0d expected <150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int model_victim(input int s);
    for (int w = 0; w < 4; w++) if (!m_val[s][w]) return w;
    if (m_root[s] == 1'b0) return m_lo[s] ? 1 : 0;
    return m_hi[s] ? 3 : 2;
  endfunction

  function automatic void model_touch(input int s, input int w);
    if (w < 2) begin
      m_root[s] = 1'b1;
      m_lo[s]   = (w == 0);
    end else begin
      m_root[s] = 1'b0;
      m_hi[s]   = (w == 2);
    end
  endfunction

  task automatic model_clear();
    for (int s = 0; s < 128; s++)
      for (int w = 0; w < 4; w++) m_val[s][w] = 1'b0;
  endtask

  // one fetch; label names the requirement the outcome tests
  task automatic fetch(input logic [31:0] a, input string label);
    int s, hw, n;
    logic [20:0] t;
    bit seen_req;
    s  = int'(a[10:4]);
    t  = a[31:11];
    hw = -1;
    for (int w = 0; w < 4; w++) if (m_val[s][w] && m_tag[s][w] == t) hw = w;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    #2;
    n = 0;
    seen_req = 1'b0;
    while (stall && n < 100) begin
      if (mem_req && !seen_req) begin
        seen_req = 1'b1;
        check({label, " R4 refill address"}, mem_addr, {a[31:4], 4'h0});
      end
      n++;
      @(negedge clk);
      #2;
    end
    check({label, hw >= 0 ? " R2 hit stall cycles" : " R3 miss stall cycles"},
          32'(n), hw >= 0 ? 32'd0 : 32'd40);
    check({label, " R2 rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({label, " R4 R5 word"}, rsp_data, mem_word(a));
    if (hw < 0) begin
      hw = model_victim(s);
      m_val[s][hw] = 1'b1;
      m_tag[s][hw] = t;
    end
    model_touch(s, hw);
  endtask

  task automatic do_flush();
    @(negedge clk);
    req_valid = 1'b0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_clear();
  endtask

  initial begin
    logic [31:0] a;
    int sets [5] = '{0, 1, 2, 5, 127};
    void'($urandom(32'd1234));
    model_clear();
    for (int s = 0; s < 128; s++) begin
      m_root[s] = 0; m_lo[s] = 0; m_hi[s] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 stall after reset", 32'(stall), 32'd0);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R1 mem_req after reset", 32'(mem_req), 32'd0);

    // cold miss then the four words of the same line
    fetch(32'h0000_1008, "R1 cold");
    fetch(32'h0000_1000, "R5 w0");
    fetch(32'h0000_1004, "R5 w1");
    fetch(32'h0000_100C, "R5 w3");

    // five tags into set 5: fills ways 0..3 in order, then tree eviction
    for (int k = 0; k < 4; k++) fetch({21'(k + 1), 7'd5, 4'h0}, "R6 fill");
    fetch({21'd1, 7'd5, 4'h4}, "R7 touch");
    fetch({21'd9, 7'd5, 4'h0}, "R7 evict");
    fetch({21'd3, 7'd5, 4'h8}, "R7 victim gone");
    fetch({21'd1, 7'd5, 4'h0}, "R7 survivor");

    // flush
    do_flush();
    fetch(32'h0000_1000, "R8 after flush");

    // random fetches over few sets and tags
    for (int i = 0; i < 300; i++) begin
      a = {21'($urandom_range(0, 5)), 7'(sets[$urandom_range(0, 4)]),
           2'($urandom_range(0, 3)), 2'b00};
      if ($urandom_range(0, 49) == 0) do_flush();
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        req_valid = 1'b0;
      end
      fetch(a, "R7 random");
    end

    @(negedge clk);
    req_valid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule